// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single host request into the command and address byte cycles that a raw NAND flash device expects on its asynchronous 8- or 16-bit bus. A request carries an opcode, an optional column address and an optional page (row) address. The block latches the request and drives the command bytes with the command latch high. It then drives the address bytes with the address latch high. Last, it waits on the device's ready line as the opcode class requires and returns a one-cycle done pulse.

Program-style requests get a pointer command placed in front of them, chosen from the column. Array reads keep chip enable forced low from the second page byte through the busy period, so no other agent on a shared bus can take the device while it fetches the page. The read wait is bounded by a budget and raises a timeout flag if the budget runs out. Reset and unclassified opcodes wait without limit.

Top module: `nand_cmd_seq`

## Requirements
- R1: For opcode 0x80, a pointer command byte goes out before the opcode. If the column is present and at or above PAGE_SIZE, the pointer is 0x50 and PAGE_SIZE is subtracted from the column. If the column is present and in 256..PAGE_SIZE-1, the pointer is 0x01 and 256 is subtracted. Otherwise the pointer is 0x00.
- R2: Command bytes go out with nand_cle_o=1 and nand_ale_o=0. Address bytes go out with nand_ale_o=1 and nand_cle_o=0. When neither a column nor a page is present, no address byte is sent. The two latches are never high together.
- R3: When wide_i=1, the column is shifted right by one before it is sent, except for the byte-wide opcodes 0x90, 0xEC, 0xEE and 0xEF. Every byte is driven on nand_dq_o[7:0], with nand_dq_o[15:8]=0.
- R4: The address bytes go out in this order: column low 8 bits, page[7:0], page[15:8], then {4'h0, page[19:16]}. The last of these is sent only when row3_i=1.
- R5: Each byte cycle holds nand_we_no low for STROBE_CYC clocks with nand_ce_no low. Data and both latch lines stay unchanged on the cycle in which nand_we_no rises.
- R6: For opcodes 0x00, 0x01 and 0x50 with a page address, nand_ce_no stays low from the second page byte until the wait ends. It is high again in the done cycle.
- R7: After the last byte of a waiting opcode, ready is not sampled for TWB_CYC clocks. With ready already high, done_o comes TWB_CYC+2 clocks after the clock in which nand_we_no last rose.
- R8: The forced-enable read wait lasts at most US_CYC*POLL_US clocks. If dev_status_i[0] never reads 1 in that time, done_o still comes, TWB_CYC+US_CYC*POLL_US+1 clocks after the last rise, and timeout_o=1.
- R9: Opcodes 0x80, 0x10, 0x60, 0xD0 and 0x70 do not wait: done_o comes one clock after the last rise of nand_we_no.
- R10: Opcode 0xFF, any unclassified opcode, and a read with no page address wait without limit for dev_status_i[0]=1. Bits 7:1 are ignored. done_o comes three clocks after the bit rises, and timeout_o=0.
- R11: done_o is a one-clock pulse, with busy_o low in that clock. busy_o is high from the clock after acceptance until done. req_i is ignored while busy. A new acceptance clears timeout_o.
- R12: After reset, busy_o=0, done_o=0, timeout_o=0, nand_ce_no=1, nand_we_no=1 and both latches are 0. The same quiet bus state holds whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| opcode_i | input | 8 | Command opcode |
| col_vld_i | input | 1 | Column address present |
| col_i | input | COL_W | Column address |
| page_vld_i | input | 1 | Page address present |
| page_i | input | 20 | Page (row) address |
| wide_i | input | 1 | 16-bit device bus |
| row3_i | input | 1 | Send third page address byte |
| dev_status_i | input | 8 | Device status; bit 0 = ready |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last read wait expired |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_dq_o | output | 16 | Data bus out |

## Verification
Byte cycles are collected at the rise of nand_we_no and compared, latch lines included, with a sequence that a behavioural model builds from the request. Completion is counted from the clock of the last rise. It is due 1 clock later for non-waiting opcodes, TWB_CYC+2 clocks later with ready high, TWB_CYC+US_CYC*POLL_US+1 clocks later on an expired read, and 3 clocks after ready rises for an unbounded wait. The bench samples every output at the falling edge and tests for equality at exactly that clock. Between acceptance and done it also checks busy_o on every clock, and after the forced-enable point it checks nand_ce_no on every clock.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_READ1   = 8'h01;
  localparam logic [7:0] OP_READOOB = 8'h50;
  localparam logic [7:0] OP_SEQIN   = 8'h80;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] OP_ERASE1  = 8'h60;
  localparam logic [7:0] OP_ERASE2  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam int ROW_W   = 20;
  localparam int MAX_CYC = 6;
  localparam int IDX_W   = $clog2(MAX_CYC + 1);

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic [7:0] val;
  } bus_cyc_t;

  typedef enum logic [1:0] {WAIT_NONE, WAIT_LIMITED, WAIT_FOREVER} wait_kind_t;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HOLD} strb_ph_t;
  typedef enum logic [1:0] {W_IDLE, W_TWB, W_POLL} wait_ph_t;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SEND, S_WAIT, S_DONE} seq_st_t;

  function automatic logic op_byte_only(input logic [7:0] op);
    return (op == 8'h90) || (op == 8'hEC) || (op == 8'hEE) || (op == 8'hEF);
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_READ0) || (op == OP_READ1) || (op == OP_READOOB);
  endfunction

  function automatic logic op_no_wait(input logic [7:0] op);
    return (op == OP_SEQIN) || (op == OP_PROG) || (op == OP_ERASE1) ||
           (op == OP_ERASE2) || (op == OP_STATUS);
  endfunction
endpackage

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
  import nand_seq_pkg::*;
#(
  parameter int PAGE_SIZE = 512,
  parameter int COL_W     = 12
) (
  input  logic [7:0]                   op_i,
  input  logic                         col_vld_i,
  input  logic [COL_W-1:0]             col_i,
  input  logic                         row_vld_i,
  input  logic [ROW_W-1:0]             row_i,
  input  logic                         wide_i,
  input  logic                         row3_i,
  output bus_cyc_t [MAX_CYC-1:0]       cyc_o,
  output logic [IDX_W-1:0]             cnt_o,
  output logic                         force_vld_o,
  output logic [IDX_W-1:0]             force_idx_o,
  output wait_kind_t                   wait_o
);
  localparam logic [COL_W-1:0] PG_LIM  = COL_W'(PAGE_SIZE);
  localparam logic [COL_W-1:0] HALF_PT = COL_W'(256);

  logic [COL_W-1:0] col_adj;
  logic [7:0]       ptr;
  logic [IDX_W-1:0] k;

  always_comb begin
    col_adj = col_i;
    ptr     = OP_READ0;
    if (col_vld_i && col_i >= PG_LIM) begin
      ptr     = OP_READOOB;
      col_adj = col_i - PG_LIM;
    end else if (col_vld_i && col_i >= HALF_PT) begin
      ptr     = OP_READ1;
      col_adj = col_i - HALF_PT;
    end
    if (op_i != OP_SEQIN) col_adj = col_i;
    if (wide_i && !op_byte_only(op_i)) col_adj = col_adj >> 1;
  end

  always_comb begin
    cyc_o       = '0;
    k           = '0;
    force_vld_o = 1'b0;
    force_idx_o = '0;
    if (op_i == OP_SEQIN) begin
      cyc_o[k] = '{cle: 1'b1, ale: 1'b0, val: ptr};
      k = k + 1'b1;
    end
    cyc_o[k] = '{cle: 1'b1, ale: 1'b0, val: op_i};
    k = k + 1'b1;
    if (col_vld_i) begin
      cyc_o[k] = '{cle: 1'b0, ale: 1'b1, val: col_adj[7:0]};
      k = k + 1'b1;
    end
    if (row_vld_i) begin
      cyc_o[k] = '{cle: 1'b0, ale: 1'b1, val: row_i[7:0]};
      k = k + 1'b1;
      force_vld_o = op_is_read(op_i);
      force_idx_o = k;
      cyc_o[k] = '{cle: 1'b0, ale: 1'b1, val: row_i[15:8]};
      k = k + 1'b1;
      if (row3_i) begin
        cyc_o[k] = '{cle: 1'b0, ale: 1'b1, val: {4'h0, row_i[19:16]}};
        k = k + 1'b1;
      end
    end
    cnt_o = k;
  end

  always_comb begin
    if (op_no_wait(op_i))                 wait_o = WAIT_NONE;
    else if (op_is_read(op_i) && row_vld_i) wait_o = WAIT_LIMITED;
    else                                  wait_o = WAIT_FOREVER;
  end
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe
  import nand_seq_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        clr_i,
  input  bus_cyc_t    cyc_i,
  output logic        we_no,
  output logic        cle_o,
  output logic        ale_o,
  output logic [15:0] dq_o,
  output logic        act_o,
  output logic        last_o
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  strb_ph_t      ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      cle_o <= 1'b0;
      ale_o <= 1'b0;
      dq_o  <= '0;
    end else if (start_i) begin
      ph_q  <= PH_LOW;
      cnt_q <= CW'(STROBE_CYC - 1);
      cle_o <= cyc_i.cle;
      ale_o <= cyc_i.ale;
      dq_o  <= {8'h00, cyc_i.val};
    end else begin
      if (clr_i) begin
        cle_o <= 1'b0;
        ale_o <= 1'b0;
      end
      unique case (ph_q)
        PH_LOW: begin
          if (cnt_q == '0) ph_q <= PH_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign we_no  = (ph_q != PH_LOW);
  assign act_o  = (ph_q != PH_IDLE);
  assign last_o = (ph_q == PH_HOLD);
endmodule

// File: rtl/nand_seq_wait.sv
module nand_seq_wait
  import nand_seq_pkg::*;
#(
  parameter int TWB_CYC   = 13,
  parameter int LIMIT_CYC = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic limited_i,
  input  logic rdy_i,
  output logic fin_o,
  output logic expired_o
);
  localparam int TOP = (LIMIT_CYC > TWB_CYC) ? LIMIT_CYC : TWB_CYC;
  localparam int CW  = $clog2(TOP + 1);

  logic [1:0]    rdy_q;
  logic          rdy_s;
  wait_ph_t      ph_q;
  logic [CW-1:0] cnt_q;
  logic          lim_q;

  assign rdy_s     = rdy_q[1];
  assign expired_o = (ph_q == W_POLL) && !rdy_s && lim_q && (cnt_q == '0);
  assign fin_o     = (ph_q == W_POLL) && (rdy_s || expired_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '0;
      ph_q  <= W_IDLE;
      cnt_q <= '0;
      lim_q <= 1'b0;
    end else begin
      rdy_q <= {rdy_q[0], rdy_i};
      if (start_i) begin
        ph_q  <= W_TWB;
        cnt_q <= CW'(TWB_CYC - 1);
        lim_q <= limited_i;
      end else begin
        unique case (ph_q)
          W_TWB: begin
            if (cnt_q == '0) begin
              ph_q  <= W_POLL;
              cnt_q <= CW'(LIMIT_CYC - 1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          W_POLL: begin
            if (fin_o)              ph_q  <= W_IDLE;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
          end
          default: ph_q <= W_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_SIZE  = 512,
  parameter int COL_W      = 12,
  parameter int STROBE_CYC = 3,
  parameter int TWB_CYC    = 13,
  parameter int US_CYC     = 125,
  parameter int POLL_US    = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [7:0]       opcode_i,
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             page_vld_i,
  input  logic [19:0]      page_i,
  input  logic             wide_i,
  input  logic             row3_i,
  input  logic [7:0]       dev_status_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic [15:0]      nand_dq_o
);
  localparam int LIMIT_CYC = US_CYC * POLL_US;

  seq_st_t          st_q;
  logic [7:0]       op_q;
  logic             col_vld_q, row_vld_q, wide_q, row3_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] idx_q;
  logic             force_q;

  bus_cyc_t [MAX_CYC-1:0] cyc;
  logic [IDX_W-1:0]       cnt, force_idx;
  logic                   force_vld;
  wait_kind_t             wkind;

  logic st_act, st_last, last_byte, seq_end, wt_fin, wt_exp;

  nand_seq_plan #(.PAGE_SIZE(PAGE_SIZE), .COL_W(COL_W)) u_plan (
    .op_i(op_q), .col_vld_i(col_vld_q), .col_i(col_q),
    .row_vld_i(row_vld_q), .row_i(row_q), .wide_i(wide_q), .row3_i(row3_q),
    .cyc_o(cyc), .cnt_o(cnt), .force_vld_o(force_vld),
    .force_idx_o(force_idx), .wait_o(wkind)
  );

  assign last_byte = (idx_q == cnt - 1'b1);
  assign seq_end   = (st_q == S_SEND) && st_last && last_byte;

  nand_seq_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(st_q == S_LOAD), .clr_i(seq_end), .cyc_i(cyc[idx_q]),
    .we_no(nand_we_no), .cle_o(nand_cle_o), .ale_o(nand_ale_o),
    .dq_o(nand_dq_o), .act_o(st_act), .last_o(st_last)
  );

  nand_seq_wait #(.TWB_CYC(TWB_CYC), .LIMIT_CYC(LIMIT_CYC)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(seq_end && (wkind != WAIT_NONE)),
    .limited_i(wkind == WAIT_LIMITED), .rdy_i(dev_status_i[0]),
    .fin_o(wt_fin), .expired_o(wt_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      op_q      <= '0;
      col_vld_q <= 1'b0;
      col_q     <= '0;
      row_vld_q <= 1'b0;
      row_q     <= '0;
      wide_q    <= 1'b0;
      row3_q    <= 1'b0;
      idx_q     <= '0;
      force_q   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          op_q      <= opcode_i;
          col_vld_q <= col_vld_i;
          col_q     <= col_i;
          row_vld_q <= page_vld_i;
          row_q     <= page_i;
          wide_q    <= wide_i;
          row3_q    <= row3_i;
          idx_q     <= '0;
          timeout_o <= 1'b0;
          st_q      <= S_LOAD;
        end
        S_LOAD: begin
          if (force_vld && idx_q == force_idx) force_q <= 1'b1;
          st_q <= S_SEND;
        end
        S_SEND: if (st_last) begin
          if (last_byte) st_q <= (wkind == WAIT_NONE) ? S_DONE : S_WAIT;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_LOAD;
          end
        end
        S_WAIT: if (wt_fin) begin
          force_q   <= 1'b0;
          timeout_o <= wt_exp;
          st_q      <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done_o     = (st_q == S_DONE);
  assign nand_ce_no = !(st_act || force_q);
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic        nand_ce_no,
  input logic        nand_cle_o,
  input logic        nand_ale_o,
  input logic        nand_we_no,
  input logic [15:0] nand_dq_o
);
  AST_STROBE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> !nand_ce_no);  // R5
  AST_LATCH_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));  // R2
  AST_DQ_HELD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> ($stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R11
  AST_TMO_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);  // R8
  AST_DONE_RELEASES_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> nand_ce_no);  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> (nand_ce_no && nand_we_no && !nand_cle_o && !nand_ale_o));  // R12
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .timeout_o(timeout_o), .nand_ce_no(nand_ce_no), .nand_cle_o(nand_cle_o),
  .nand_ale_o(nand_ale_o), .nand_we_no(nand_we_no), .nand_dq_o(nand_dq_o)
);

// File: tb/nand_cmd_seq_tb.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb;
  localparam int PAGE = 512;
  localparam int TWB  = 13;
  localparam int LIM  = 125 * 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  op = '0;
  logic        cv = 1'b0, pv = 1'b0, w16 = 1'b0, r3 = 1'b0;
  logic [11:0] col = '0;
  logic [19:0] page = '0;
  logic [7:0]  stat = 8'hA5;
  logic        busy, done, tmo, ce_n, cle, ale, we_n;
  logic [15:0] dq;

  int total = 0;
  int bad = 0;
  int wd = 0;

  always #4 clk = ~clk;

  nand_cmd_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .opcode_i(op),
    .col_vld_i(cv), .col_i(col), .page_vld_i(pv), .page_i(page),
    .wide_i(w16), .row3_i(r3), .dev_status_i(stat),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .nand_ce_no(ce_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_dq_o(dq)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<190000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Behavioural model of the byte cycles: {cle, ale, dq[15:0]}
  task automatic build_exp(input logic [7:0] o, input bit c_v, input int c_in,
                           input bit p_v, input int pg, input bit wd16,
                           input bit rw3, ref logic [17:0] q[$], output int fidx);
    int c;
    c = c_in;
    q.delete();
    fidx = -1;
    if (o == 8'h80) begin
      if (c_v && c >= PAGE) begin
        q.push_back({2'b10, 16'h0050}); c = c - PAGE;
      end else if (c_v && c >= 256) begin
        q.push_back({2'b10, 16'h0001}); c = c - 256;
      end else q.push_back({2'b10, 16'h0000});
    end
    q.push_back({2'b10, 8'h00, o});
    if (c_v) begin
      if (wd16 && !(o == 8'h90 || o == 8'hEC || o == 8'hEE || o == 8'hEF)) c = c / 2;
      q.push_back({2'b01, 8'h00, 8'(c)});
    end
    if (p_v) begin
      q.push_back({2'b01, 8'h00, 8'(pg)});
      if (o == 8'h00 || o == 8'h01 || o == 8'h50) fidx = q.size();
      q.push_back({2'b01, 8'h00, 8'(pg >> 8)});
      if (rw3) q.push_back({2'b01, 12'h000, 4'(pg >> 16)});
    end
  endtask

  // raise_at: clocks after the last strobe rise at which ready goes high (0 = already high)
  task automatic run_op(input string rq, input logic [7:0] o, input bit c_v,
                        input int c_in, input bit p_v, input int pg,
                        input bit wd16, input bit rw3, input int raise_at,
                        input int exp_dly, input bit exp_tmo, input bit poke);
    logic [17:0] exp_q[$];
    logic [17:0] got_q[$];
    int fidx, cyc, last_rise, done_cyc, busy_err, ce_err;
    logic prev_we;
    build_exp(o, c_v, c_in, p_v, pg, wd16, rw3, exp_q, fidx);
    cyc = 0; last_rise = -1; done_cyc = -1; busy_err = 0; ce_err = 0;
    prev_we = 1'b1;
    @(negedge clk);
    stat = (raise_at == 0) ? 8'hA5 : 8'hA4;
    op = o; cv = c_v; col = 12'(c_in); pv = p_v; page = 20'(pg);
    w16 = wd16; r3 = rw3; req = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cyc++;
      req = 1'b0;
      if (done) begin
        done_cyc = cyc;
        chk(ce_n == 1'b1, "R6", "ce released at done", ce_n, 1);
        break;
      end
      if (!busy) busy_err++;
      if (!prev_we && we_n) begin
        got_q.push_back({cle, ale, dq});
        last_rise = cyc;
        if (ce_n) ce_err++;
      end
      if (fidx >= 0 && got_q.size() >= fidx + 1 && ce_n) ce_err++;
      prev_we = we_n;
      if (poke && cyc == 2) begin
        req = 1'b1; op = 8'hFF; pv = 1'b1;
      end
      if (raise_at > 0 && last_rise >= 0 && got_q.size() == exp_q.size() &&
          cyc == last_rise + raise_at) stat = 8'hA5;
    end
    chk(busy_err == 0, "R11", "busy until done", busy_err, 0);
    chk(ce_err == 0, "R6", "ce low at strobe/forced window", ce_err, 0);
    chk(got_q.size() == exp_q.size(), rq, "byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], rq, $sformatf("byte %0d {cle,ale,dq}", i), got_q[i], exp_q[i]);
    chk(done_cyc >= 0 && done_cyc - last_rise == exp_dly, rq, "done delay",
        done_cyc - last_rise, exp_dly);
    chk(tmo == exp_tmo, (exp_tmo ? "R8" : "R11"), "timeout flag", tmo, exp_tmo);
    @(negedge clk);
    chk(!done && !busy, "R11", "done is a pulse", {done, busy}, 0);
    stat = 8'hA5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, tmo, ce_n, we_n, cle, ale} == 7'b0001100, "R12", "reset state",
        {busy, done, tmo, ce_n, we_n, cle, ale}, 7'b0001100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, ce_n, we_n, cle, ale} == 5'b01100, "R12", "idle after reset",
        {busy, ce_n, we_n, cle, ale}, 5'b01100);

    // R1 R4 R9: program low column, two row bytes
    run_op("R1", 8'h80, 1, 10, 1, 'h12345, 0, 0, 0, 1, 0, 0);
    // R1 R4: upper half column, third row byte
    run_op("R4", 8'h80, 1, 300, 1, 'h9ABCD, 0, 1, 0, 1, 0, 0);
    // R1 R3: spare area column on 16-bit bus
    run_op("R3", 8'h80, 1, 520, 1, 'h00777, 1, 0, 0, 1, 0, 0);
    // R6 R7: read with page, ready high
    run_op("R7", 8'h00, 1, 510, 1, 'h0BEEF, 0, 0, 0, TWB + 2, 0, 0);
    // R6 R8: read with page, ready never comes
    run_op("R8", 8'h00, 1, 200, 1, 'h54321, 1, 1, 100000, TWB + LIM + 1, 1, 0);
    // R3 R10: byte-wide opcode keeps its column on 16-bit bus, clears timeout
    run_op("R3", 8'h90, 1, 'h20, 0, 0, 1, 0, 0, TWB + 2, 0, 0);
    // R10 R2: reset with no address, ready rises well past the read budget
    run_op("R10", 8'hFF, 0, 0, 0, 0, 0, 0, 5000, 5003, 0, 0);
    // R9 R11: status, second request while busy is ignored
    run_op("R11", 8'h70, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    repeat (20) @(negedge clk);
    chk(!busy && we_n && ce_n, "R11", "ignored request left no work", {busy, we_n, ce_n}, 3'b011);
    // R4 R9: erase setup with page only and three row bytes
    run_op("R4", 8'h60, 0, 0, 1, 'hF1234, 0, 1, 0, 1, 0, 0);
    run_op("R9", 8'hD0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R10: read without page falls back to unbounded wait, no forced enable
    run_op("R10", 8'h01, 1, 77, 0, 0, 0, 0, 0, TWB + 2, 0, 0);
    // R5: strobe width visible on a plain command
    @(negedge clk);
    op = 8'h10; cv = 0; pv = 0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    begin
      int lo;
      lo = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!we_n) lo++;
      end
      chk(lo == 3, "R5", "strobe low clocks", lo, 3);
    end
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule